// File: doc/BRIEF.md
# Core Reset and FIFO Flush Controller

This block owns the single reset/flush control register of a USB-style controller core. Software writes request bits into it. The block turns each bit into a request level toward the logic that does the work: the whole core, the bus-clock domain, the host frame counter, the receive FIFO, or one or all transmit FIFOs. Each bit stays set, and reads back as 1, until that logic reports completion. Software starts an action by writing 1 and polls the bit until it reads 0.

Flush bits have a fixed minimum lifetime, `FLUSH_MIN` cycles, counted by an internal timer. A flush bit clears only when the timer has expired and the FIFO side has raised its done input at least once. A core soft reset waits for done from both the core domain and the bus domain. While it runs it blocks every flush request, pulses a clear to the interrupt mask bits, and takes any pending flush bits down with it when it finishes. It does not touch interrupt status or configuration state.

The block moves no data, so it has no valid/ready stream. The register port is a single-cycle write strobe with a combinational read and no back-pressure. All request, done and status pins are plain levels.

Top module: `core_rst_ctrl`

## Requirements
- R1: Writing 1 to a request bit (bit 0 core reset, bit 1 bus-domain reset, bit 2 frame-counter reset, bit 4 receive flush, bit 5 transmit flush) sets it in the cycle after the write. Writing 0 to a pending bit, or writing 1 to it again, has no effect. A rewrite does not restart the flush timer.
- R2: The core reset bit (bit 0) clears on the first clock edge at which both core-domain done and bus-domain done have each been seen since the request. If done arrives in the cycle after edge a and edge b, the bit stays high for max(a,b)+1 cycles. While the core reset is pending, bus_rst_req is also high.
- R3: Accepting a core reset request pulses int_mask_clr for exactly one cycle, in the same cycle that bit 0 first reads 1.
- R4: The bus-domain reset bit clears on the first edge at which bus_rst_done is high. The frame-counter reset bit does the same with frame_rst_done. Their request outputs follow the bits.
- R5: A flush bit (bit 4 or 5) stays high for max(FLUSH_MIN, d+1) cycles, where the FIFO done pulse comes in the cycle after edge d of the request.
- R6: The transmit FIFO number is bits 10:6. While a transmit flush is requested, txf_flush_map has bit n set for code n (0 is the non-periodic FIFO, 1 to 15 are periodic FIFOs), all bits set for code 16, and no bits set for codes 17 to 31.
- R7: Bits 10:6 take the written value on any write while no transmit flush is pending. Writes to those bits while a transmit flush is pending are ignored.
- R8: While a core reset is pending, rxf_flush_req and txf_flush_req stay low. Any pending flush bit clears on the same edge as the core reset bit.
- R9: Bit 30 reads dma_busy and bit 31 reads master_idle. Bit 3 and bits 29:11 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value |
| core_rst_req | output | 1 | Whole-core soft reset request |
| core_rst_done | input | 1 | Core domain finished its reset |
| bus_rst_req | output | 1 | Bus-clock-domain reset request |
| bus_rst_done | input | 1 | Bus domain finished its reset |
| frame_rst_req | output | 1 | Frame counter reset request |
| frame_rst_done | input | 1 | Frame counter has been zeroed |
| int_mask_clr | output | 1 | One-cycle pulse clearing interrupt masks |
| rxf_flush_req | output | 1 | Receive FIFO flush request |
| rxf_flush_done | input | 1 | Receive FIFO flush finished |
| txf_flush_req | output | 1 | Transmit FIFO flush request |
| txf_flush_map | output | TXF_COUNT | Transmit FIFOs chosen for the flush |
| txf_flush_done | input | 1 | Transmit FIFO flush finished |
| dma_busy | input | 1 | DMA request in progress (status) |
| master_idle | input | 1 | Bus master state machine idle (status) |

## Verification
A wrong timer or done-latch state shows up in the length of a flush bit's pulse, one cycle per error. The bench therefore counts high cycles while it sweeps the done arrival across and past the minimum. A stale FIFO-number register is visible in the cycle after the write, both in the read-back field and in txf_flush_map. A wrong priority between core reset and flush shows as a flush request that leaks out during the reset, or a flush bit that outlives it by one or more cycles.

// File: rtl/core_rst_pkg.sv
package core_rst_pkg;
  // Register bit positions; software decodes these.
  localparam int BIT_CORE  = 0;
  localparam int BIT_BUS   = 1;
  localparam int BIT_FRAME = 2;
  localparam int BIT_RXF   = 4;
  localparam int BIT_TXF   = 5;
  localparam int SEL_LO    = 6;
  localparam int SEL_W     = 5;
  localparam int BIT_DMA   = 30;
  localparam int BIT_IDLE  = 31;
  // Transmit FIFO number that selects every FIFO.
  localparam logic [SEL_W-1:0] SEL_ALL = 5'd16;
endpackage

// File: rtl/req_slot.sv
// Self-clearing request bit that waits for done from N_DONE domains.
module req_slot #(
  parameter int N_DONE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [N_DONE-1:0] done,
  output logic              pend,
  output logic              fin
);
  logic [N_DONE-1:0] seen;
  logic [N_DONE-1:0] got;

  assign got = seen | done;
  assign fin = pend & (&got);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      seen <= '0;
    end else if (pend) begin
      if (fin) begin
        pend <= 1'b0;
        seen <= '0;
      end else begin
        seen <= got;
      end
    end else if (set) begin
      pend <= 1'b1;
      seen <= '0;
    end
  end
endmodule

// File: rtl/flush_slot.sv
// Self-clearing flush bit with a minimum lifetime and a done handshake.
module flush_slot #(
  parameter int MIN_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic done,
  input  logic hold,   // core reset in progress: suppress and freeze
  input  logic kill,   // core reset finishing: drop the request
  output logic pend,
  output logic req
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] cnt;
  logic          seen;
  logic          at_min;
  logic          fin;

  assign at_min = (cnt == LAST);
  assign fin    = pend & ~hold & at_min & (seen | done);
  assign req    = pend & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      cnt  <= '0;
      seen <= 1'b0;
    end else if (pend) begin
      if (fin || kill) begin
        pend <= 1'b0;
        cnt  <= '0;
        seen <= 1'b0;
      end else if (hold) begin
        cnt  <= '0;
        seen <= 1'b0;
      end else begin
        if (!at_min) cnt <= cnt + 1'b1;
        seen <= seen | done;
      end
    end else if (set) begin
      pend <= 1'b1;
      cnt  <= '0;
      seen <= 1'b0;
    end
  end
endmodule

// File: rtl/txf_decode.sv
// Maps the transmit FIFO number onto a per-FIFO flush vector.
module txf_decode
  import core_rst_pkg::*;
#(
  parameter int COUNT = 16
) (
  input  logic [SEL_W-1:0] code,
  output logic [COUNT-1:0] map
);
  for (genvar i = 0; i < COUNT; i++) begin : g_fifo
    assign map[i] = (code == SEL_ALL) | (code == SEL_W'(i));
  end
endmodule

// File: rtl/core_rst_ctrl.sv
module core_rst_ctrl
  import core_rst_pkg::*;
#(
  parameter int FLUSH_MIN = 8,
  parameter int TXF_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_data,
  output logic                 core_rst_req,
  input  logic                 core_rst_done,
  output logic                 bus_rst_req,
  input  logic                 bus_rst_done,
  output logic                 frame_rst_req,
  input  logic                 frame_rst_done,
  output logic                 int_mask_clr,
  output logic                 rxf_flush_req,
  input  logic                 rxf_flush_done,
  output logic                 txf_flush_req,
  output logic [TXF_COUNT-1:0] txf_flush_map,
  input  logic                 txf_flush_done,
  input  logic                 dma_busy,
  input  logic                 master_idle
);
  logic core_pend, core_fin;
  logic bus_pend, bus_fin;
  logic frame_pend, frame_fin;
  logic rxf_pend, txf_pend;
  logic rxf_req_i, txf_req_i;
  logic mask_q;
  logic [SEL_W-1:0] sel_q;
  logic [TXF_COUNT-1:0] map_i;

  req_slot #(.N_DONE(2)) u_core (
    .clk(clk), .rst_n(rst_n),
    .set(wr_en & wr_data[BIT_CORE]),
    .done({bus_rst_done, core_rst_done}),
    .pend(core_pend), .fin(core_fin)
  );

  req_slot #(.N_DONE(1)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .set(wr_en & wr_data[BIT_BUS]),
    .done(bus_rst_done),
    .pend(bus_pend), .fin(bus_fin)
  );

  req_slot #(.N_DONE(1)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .set(wr_en & wr_data[BIT_FRAME]),
    .done(frame_rst_done),
    .pend(frame_pend), .fin(frame_fin)
  );

  flush_slot #(.MIN_CYC(FLUSH_MIN)) u_rxf (
    .clk(clk), .rst_n(rst_n),
    .set(wr_en & wr_data[BIT_RXF]),
    .done(rxf_flush_done),
    .hold(core_pend), .kill(core_fin),
    .pend(rxf_pend), .req(rxf_req_i)
  );

  flush_slot #(.MIN_CYC(FLUSH_MIN)) u_txf (
    .clk(clk), .rst_n(rst_n),
    .set(wr_en & wr_data[BIT_TXF]),
    .done(txf_flush_done),
    .hold(core_pend), .kill(core_fin),
    .pend(txf_pend), .req(txf_req_i)
  );

  txf_decode #(.COUNT(TXF_COUNT)) u_dec (
    .code(sel_q),
    .map(map_i)
  );

  // FIFO number is frozen while a transmit flush is outstanding.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      if (wr_en && !txf_pend) sel_q <= wr_data[SEL_LO +: SEL_W];
      mask_q <= wr_en & wr_data[BIT_CORE] & ~core_pend;
    end
  end

  assign core_rst_req  = core_pend;
  assign bus_rst_req   = bus_pend | core_pend;
  assign frame_rst_req = frame_pend;
  assign int_mask_clr  = mask_q;
  assign rxf_flush_req = rxf_req_i;
  assign txf_flush_req = txf_req_i;
  assign txf_flush_map = txf_req_i ? map_i : '0;

  always_comb begin
    rd_data                     = '0;
    rd_data[BIT_CORE]           = core_pend;
    rd_data[BIT_BUS]            = bus_pend;
    rd_data[BIT_FRAME]          = frame_pend;
    rd_data[BIT_RXF]            = rxf_pend;
    rd_data[BIT_TXF]            = txf_pend;
    rd_data[SEL_LO +: SEL_W]    = sel_q;
    rd_data[BIT_DMA]            = dma_busy;
    rd_data[BIT_IDLE]           = master_idle;
  end
endmodule

// File: rtl/core_rst_checker.sv
module core_rst_checker #(
  parameter int FLUSH_MIN = 8,
  parameter int TXF_COUNT = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [31:0]          wr_data,
  input logic [31:0]          rd_data,
  input logic                 int_mask_clr,
  input logic                 rxf_flush_req,
  input logic                 txf_flush_req,
  input logic [TXF_COUNT-1:0] txf_flush_map
);
  localparam int RW = $clog2(FLUSH_MIN + 2);
  localparam logic [RW-1:0] RSAT = RW'(FLUSH_MIN);

  logic [RW-1:0] rx_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_run <= '0;
    else if (rd_data[4]) rx_run <= (rx_run == RSAT) ? rx_run : rx_run + 1'b1;
    else rx_run <= '0;
  end

  assert_set_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1] && !rd_data[1]) |=> rd_data[1]);

  assert_mask_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_mask_clr |-> (rd_data[0] && !$past(rd_data[0])));

  assert_mask_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_mask_clr |=> !int_mask_clr);

  assert_flush_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_data[4]) && !rd_data[4] && !$past(rd_data[0])) |-> (rx_run >= RSAT));

  assert_map_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (txf_flush_req && rd_data[10:6] != 5'd16) |-> $onehot0(txf_flush_map));

  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_data[5]) && rd_data[5]) |-> (rd_data[10:6] == $past(rd_data[10:6])));

  assert_core_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |-> (!rxf_flush_req && !txf_flush_req));

  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[29:11] == 19'd0) && !rd_data[3]);
endmodule

bind core_rst_ctrl core_rst_checker #(
  .FLUSH_MIN(FLUSH_MIN),
  .TXF_COUNT(TXF_COUNT)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .wr_en(wr_en),
  .wr_data(wr_data),
  .rd_data(rd_data),
  .int_mask_clr(int_mask_clr),
  .rxf_flush_req(rxf_flush_req),
  .txf_flush_req(txf_flush_req),
  .txf_flush_map(txf_flush_map)
);

// File: tb/core_rst_ctrl_bench.sv
`timescale 1ns/1ps
module core_rst_ctrl_bench;
  localparam int MIN = 8;
  localparam int NTX = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic core_rst_req, bus_rst_req, frame_rst_req, int_mask_clr;
  logic rxf_flush_req, txf_flush_req;
  logic [NTX-1:0] txf_flush_map;
  logic core_rst_done = 1'b0, bus_rst_done = 1'b0, frame_rst_done = 1'b0;
  logic rxf_flush_done = 1'b0, txf_flush_done = 1'b0;
  logic dma_busy = 1'b0, master_idle = 1'b0;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  core_rst_ctrl #(.FLUSH_MIN(MIN), .TXF_COUNT(NTX)) u_core_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .core_rst_req(core_rst_req), .core_rst_done(core_rst_done),
    .bus_rst_req(bus_rst_req), .bus_rst_done(bus_rst_done),
    .frame_rst_req(frame_rst_req), .frame_rst_done(frame_rst_done),
    .int_mask_clr(int_mask_clr),
    .rxf_flush_req(rxf_flush_req), .rxf_flush_done(rxf_flush_done),
    .txf_flush_req(txf_flush_req), .txf_flush_map(txf_flush_map),
    .txf_flush_done(txf_flush_done),
    .dma_busy(dma_busy), .master_idle(master_idle)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write at the edge; returns at the negedge after it.
  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  function automatic logic [NTX-1:0] exp_map(input int code);
    if (code < NTX) return NTX'(1) << code;
    if (code == 16) return '1;
    return '0;
  endfunction

  // Flush with a one-cycle done pulse after edge d; returns cycles high.
  task automatic flush_run(input int bitpos, input int d, output int n);
    n = 0;
    wr(32'(1) << bitpos);
    for (int k = 0; k < 40; k++) begin
      if (!rd_data[bitpos]) break;
      n++;
      if (bitpos == 4) chk("R5 rx req follows bit", {31'd0, rxf_flush_req}, 32'd1);
      else             chk("R5 tx req follows bit", {31'd0, txf_flush_req}, 32'd1);
      rxf_flush_done = (bitpos == 4) && (k == d);
      txf_flush_done = (bitpos == 5) && (k == d);
      @(negedge clk);
    end
    rxf_flush_done = 1'b0;
    txf_flush_done = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset read", rd_data, 32'd0);
    chk("R1 reset reqs", {27'd0, core_rst_req, bus_rst_req, frame_rst_req, rxf_flush_req, txf_flush_req}, 32'd0);

    // R9 status and reserved bits
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      dma_busy = s[0];
      master_idle = s[1];
      #1;
      chk("R9 status bits", {30'd0, rd_data[31:30]}, {30'd0, s[1], s[0]});
      chk("R9 reserved zero", rd_data & 32'h3FFF_F808, 32'd0);
    end
    dma_busy = 1'b0;
    master_idle = 1'b0;
    wr(32'h3FFF_F808);
    chk("R9 reserved writes ignored", rd_data & 32'h3FFF_F808, 32'd0);

    // R5 flush latency sweep on both flush bits
    for (int b = 4; b <= 5; b++) begin
      for (int d = 0; d < 12; d++) begin
        flush_run(b, d, n);
        chk("R5 flush length", 32'(n), 32'((d + 1 > MIN) ? d + 1 : MIN));
      end
    end

    // R1 write 0 and rewrite do not cancel or restart
    rxf_flush_done = 1'b1;
    wr(32'h10);
    n = 1;
    for (int k = 1; k < 40; k++) begin
      if (k == 2) begin
        wr_en = 1'b1; wr_data = 32'h0;
      end else if (k == 4) begin
        wr_en = 1'b1; wr_data = 32'h10;
      end else begin
        wr_en = 1'b0; wr_data = '0;
      end
      @(negedge clk);
      if (!rd_data[4]) break;
      n++;
    end
    wr_en = 1'b0;
    rxf_flush_done = 1'b0;
    chk("R1 write0 and rewrite keep timer", 32'(n), 32'(MIN));

    // R2/R3 core reset needs both domains
    for (int a = 0; a < 5; a++) begin
      for (int bb = 0; bb < 5; bb++) begin
        wr(32'h1);
        n = 0;
        chk("R3 mask pulse", {31'd0, int_mask_clr}, 32'd1);
        for (int k = 0; k < 20; k++) begin
          if (!rd_data[0]) break;
          n++;
          chk("R2 bus req during core", {30'd0, core_rst_req, bus_rst_req}, 32'd3);
          if (k == 1) chk("R3 mask single", {31'd0, int_mask_clr}, 32'd0);
          core_rst_done = (k == a);
          bus_rst_done = (k == bb);
          @(negedge clk);
        end
        core_rst_done = 1'b0;
        bus_rst_done = 1'b0;
        chk("R2 core length", 32'(n), 32'(((a > bb) ? a : bb) + 1));
        @(negedge clk);
        chk("R3 mask idle after", {31'd0, int_mask_clr}, 32'd0);
      end
    end

    // R4 bus-only and frame resets
    for (int d = 0; d < 5; d++) begin
      for (int w = 0; w < 2; w++) begin
        wr(w == 0 ? 32'h2 : 32'h4);
        n = 0;
        for (int k = 0; k < 20; k++) begin
          if (!rd_data[w == 0 ? 1 : 2]) break;
          n++;
          if (w == 0) chk("R4 bus req", {31'd0, bus_rst_req}, 32'd1);
          else        chk("R4 frame req", {31'd0, frame_rst_req}, 32'd1);
          bus_rst_done = (w == 0) && (k == d);
          frame_rst_done = (w == 1) && (k == d);
          @(negedge clk);
        end
        bus_rst_done = 1'b0;
        frame_rst_done = 1'b0;
        chk("R4 reset length", 32'(n), 32'(d + 1));
      end
    end

    // R6/R7 transmit FIFO number sweep
    for (int c = 0; c < 32; c++) begin
      wr(32'h20 | (32'(c) << 6));
      chk("R6 map", 32'(txf_flush_map), 32'(exp_map(c)));
      chk("R7 field loaded", {27'd0, rd_data[10:6]}, 32'(c));
      wr(32'((c ^ 31)) << 6);
      chk("R7 field frozen", {27'd0, rd_data[10:6]}, 32'(c));
      chk("R6 map frozen", 32'(txf_flush_map), 32'(exp_map(c)));
      txf_flush_done = 1'b1;
      for (int k = 0; k < 20; k++) begin
        if (!rd_data[5]) break;
        @(negedge clk);
      end
      txf_flush_done = 1'b0;
      chk("R6 map idle", 32'(txf_flush_map), 32'd0);
      wr(32'((c ^ 31)) << 6);
      chk("R7 field free", {27'd0, rd_data[10:6]}, 32'(c ^ 31));
    end

    // R8 core reset overrides and clears flushes
    for (int d = 1; d < 12; d += 3) begin
      wr(32'h30);
      wr(32'h1);
      rxf_flush_done = 1'b1;
      txf_flush_done = 1'b1;
      n = 0;
      for (int k = 0; k < 20; k++) begin
        if (!rd_data[0]) break;
        n++;
        chk("R8 flush reqs gated", {30'd0, rxf_flush_req, txf_flush_req}, 32'd0);
        chk("R8 flush bits held", {30'd0, rd_data[5:4]}, 32'd3);
        core_rst_done = (k == d);
        bus_rst_done = (k == d);
        @(negedge clk);
      end
      core_rst_done = 1'b0;
      bus_rst_done = 1'b0;
      rxf_flush_done = 1'b0;
      txf_flush_done = 1'b0;
      chk("R8 core length", 32'(n), 32'(d + 1));
      chk("R8 flush bits cleared with core", {30'd0, rd_data[5:4]}, 32'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule